// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises a host processor. The host proves it is alive by producing falling edges on a trigger input, and the block answers a missing or misplaced trigger with an active-low reset pulse of fixed length. After reset, or after the block is re-enabled, it is in a power-up phase. In that phase there is no window, and the first falling edge at any time is accepted. If the power-up time runs out without a trigger, a reset pulse is issued and the power-up phase starts again, as often as needed.

Once a first trigger has been accepted, the block runs in windowed mode. Each period is measured from the last accepted trigger or from the end of the last reset pulse. A trigger in the first half of the period is treated as a fault, in the same way as a trigger that never arrives. The period and power-up lengths are inputs given in clock cycles, and the pulse length is a parameter. A mode controller can freeze the block through an enable input. A separate disable input turns supervision off altogether. All inputs are synchronous to `clk`.

Top module: `wdog_top`

## Requirements
- R1: The only trigger event is a falling edge of `trig_i`, seen as high at one rising clock edge and low at the next. Rising edges and steady levels have no effect on timing.
- R2: While `rst` is high and after it is released, `wdrst_n_o` is high and the block is in the power-up phase. In that phase any falling edge is accepted and ends the phase without a pulse.
- R3: In the power-up phase with no trigger, `wdrst_n_o` goes low exactly `powerup_cyc_i` cycles after the phase starts (a value of 0 counts as 1). It stays low for exactly `PULSE_CYC` cycles, then the power-up phase restarts, without limit.
- R4: An accepted power-up trigger starts the first windowed period at the clock edge that detects it.
- R5: In windowed mode, a trigger detected when at least floor(P/2) cycles of the current period have passed is accepted. Here P is `period_cyc_i`, with values below 2 taken as 2. `wdrst_n_o` stays high and a new period starts at that edge.
- R6: In windowed mode, a trigger detected earlier than R5 allows drives `wdrst_n_o` low in the next cycle for `PULSE_CYC` cycles.
- R7: In windowed mode with no accepted trigger, `wdrst_n_o` goes low exactly P cycles after the period start for `PULSE_CYC` cycles. A trigger detected on that last cycle is still accepted.
- R8: After any pulse in windowed mode, the next period starts when `wdrst_n_o` rises, and the block stays in windowed mode.
- R9: Falling edges while `wdrst_n_o` is low are ignored. They neither lengthen nor shorten the pulse, and they do not shift the following period.
- R10: While `disable_i` is high, `wdrst_n_o` stays high and all timing is held cleared. When `disable_i` falls, a fresh power-up phase starts.
- R11: While `enable_i` is low, `wdrst_n_o` is high, a pulse in progress is cut off and all timing is held cleared. When `enable_i` rises, a fresh power-up phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Enable from the mode controller; low freezes and clears the block |
| disable_i | input | 1 | High turns supervision off |
| period_cyc_i | input | 16 | Windowed period P in clock cycles |
| powerup_cyc_i | input | 16 | Power-up phase length in clock cycles |
| trig_i | input | 1 | Trigger input from the host; falling edges count |
| wdrst_n_o | output | 1 | Active-low reset pulse to the host |

## Verification
A count that is off by one shifts the falling edge of `wdrst_n_o` by one cycle. This shows at the first expiry, within one power-up time or one period, or at the first trigger placed on a window boundary. A wrong window start shows as a pulse, or as no pulse, in the cycle right after a trigger detected one cycle either side of floor(P/2). A lost windowed-mode flag shows at the next pulse: the following high time equals the power-up length instead of P. An enable or disable that does not clear the block shows as a low output or a shortened first power-up phase once the input is released.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    parameter int unsigned WD_CNT_W = 16;

    typedef logic [WD_CNT_W-1:0] wd_cnt_t;

    // bit 1 of the encoding is the "reset pulse active" flag
    typedef enum logic [1:0] {
        WD_PWRUP = 2'b00,
        WD_RUN   = 2'b01,
        WD_PULSE = 2'b10
    } wd_state_e;

    typedef struct packed {
        wd_cnt_t term;    // counter value on the last cycle of the phase
        wd_cnt_t win_lo;  // first counter value inside the trigger window
    } wd_lim_t;

    function automatic wd_cnt_t at_least(wd_cnt_t len, wd_cnt_t floor_len);
        return (len < floor_len) ? floor_len : len;
    endfunction

    function automatic logic pulse_active(wd_state_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/wdog_edge.sv
module wdog_edge (
    input  logic clk,
    input  logic trig_i,
    output logic fall_o
);
    logic trig_q;

    // previous sample of the trigger; tracks the input in every mode so a
    // level held across reset or disable never looks like an edge
    always_ff @(posedge clk) begin
        trig_q <= trig_i;
    end

    assign fall_o = trig_q & ~trig_i;
endmodule

// File: rtl/wdog_limits.sv
module wdog_limits
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 8
) (
    input  wd_state_e st_i,
    input  wd_cnt_t   period_cyc_i,
    input  wd_cnt_t   powerup_cyc_i,
    output wd_lim_t   lim_o
);
    localparam wd_cnt_t PULSE_LAST = wd_cnt_t'(PULSE_CYC - 1);

    wd_cnt_t per_len;
    wd_cnt_t pu_len;

    assign per_len = at_least(period_cyc_i, wd_cnt_t'(2));
    assign pu_len  = at_least(powerup_cyc_i, wd_cnt_t'(1));

    always_comb begin
        lim_o.win_lo = per_len >> 1;
        unique case (st_i)
            WD_PWRUP: lim_o.term = pu_len - 1'b1;
            WD_RUN:   lim_o.term = per_len - 1'b1;
            WD_PULSE: lim_o.term = PULSE_LAST;
            default:  lim_o.term = PULSE_LAST;
        endcase
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_en_i,
    input  logic      fall_i,
    input  wd_lim_t   lim_i,
    output wd_state_e st_o,
    output wd_cnt_t   cnt_o
);
    wd_state_e st_q;
    wd_cnt_t   cnt_q;
    logic      armed_q;   // a first trigger has been accepted
    logic      at_end;
    logic      in_win;

    assign at_end = (cnt_q == lim_i.term);
    assign in_win = (cnt_q >= lim_i.win_lo);

    always_ff @(posedge clk) begin
        if (rst || !run_en_i) begin
            st_q    <= WD_PWRUP;
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            unique case (st_q)
                WD_PWRUP: begin
                    if (fall_i) begin
                        st_q    <= WD_RUN;
                        cnt_q   <= '0;
                        armed_q <= 1'b1;
                    end else if (at_end) begin
                        st_q  <= WD_PULSE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                WD_RUN: begin
                    if (fall_i && in_win) begin
                        cnt_q <= '0;
                    end else if (fall_i || at_end) begin
                        st_q  <= WD_PULSE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                WD_PULSE: begin
                    if (at_end) begin
                        st_q  <= armed_q ? WD_RUN : WD_PWRUP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= WD_PWRUP;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign st_o  = st_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable_i,
    input  logic                disable_i,
    input  logic [WD_CNT_W-1:0] period_cyc_i,
    input  logic [WD_CNT_W-1:0] powerup_cyc_i,
    input  logic                trig_i,
    output logic                wdrst_n_o
);
    logic      run_en;
    logic      fall_w;
    wd_state_e st_w;
    wd_cnt_t   cnt_w;
    wd_lim_t   lim_w;

    assign run_en = enable_i & ~disable_i;

    wdog_edge edge_i (
        .clk    (clk),
        .trig_i (trig_i),
        .fall_o (fall_w)
    );

    wdog_limits #(.PULSE_CYC(PULSE_CYC)) limits_i (
        .st_i          (st_w),
        .period_cyc_i  (period_cyc_i),
        .powerup_cyc_i (powerup_cyc_i),
        .lim_o         (lim_w)
    );

    wdog_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .run_en_i (run_en),
        .fall_i   (fall_w),
        .lim_i    (lim_w),
        .st_o     (st_w),
        .cnt_o    (cnt_w)
    );

    // output comes straight from a state register bit
    assign wdrst_n_o = ~pulse_active(st_w);
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 8
) (
    input logic      clk,
    input logic      rst,
    input logic      enable_i,
    input logic      disable_i,
    input logic      trig_fall,
    input wd_state_e st,
    input wd_cnt_t   cnt,
    input wd_lim_t   lim,
    input logic      wdrst_n_o
);
    logic    run;
    wd_cnt_t low_run;

    assign run = enable_i & ~disable_i;

    always_ff @(posedge clk) begin
        if (rst || wdrst_n_o) low_run <= '0;
        else                  low_run <= low_run + 1'b1;
    end

    // R2: a power-up trigger is accepted without a pulse
    a_r2_pwrup_accept: assert property (@(posedge clk) disable iff (rst)
        (st == WD_PWRUP && trig_fall && run) |=> (st == WD_RUN && cnt == '0 && wdrst_n_o));

    // R3: no pulse is longer than the pulse length
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
        !wdrst_n_o |-> (low_run < wd_cnt_t'(PULSE_CYC)));

    // R5: trigger inside the window restarts the period, no pulse
    a_r5_in_window: assert property (@(posedge clk) disable iff (rst)
        (st == WD_RUN && trig_fall && run && cnt >= lim.win_lo) |=> (wdrst_n_o && cnt == '0));

    // R6: early trigger starts a pulse in the next cycle
    a_r6_early: assert property (@(posedge clk) disable iff (rst)
        (st == WD_RUN && trig_fall && run && cnt < lim.win_lo) |=> !wdrst_n_o);

    // R9: an edge during a pulse does not end it early
    a_r9_ignore: assert property (@(posedge clk) disable iff (rst)
        (st == WD_PULSE && trig_fall && run && cnt != lim.term) |=> (st == WD_PULSE));

    // R10: disabled block keeps the output high
    a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
        disable_i |=> wdrst_n_o);

    // R11: enable low clears timing and releases the output
    a_r11_enable_low: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (wdrst_n_o && cnt == '0));
endmodule

bind wdog_top wdog_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (enable_i),
    .disable_i (disable_i),
    .trig_fall (fall_w),
    .st        (st_w),
    .cnt       (cnt_w),
    .lim       (lim_w),
    .wdrst_n_o (wdrst_n_o)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 8;
    localparam int PU         = 12;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [15:0] per;     // period P
        logic [15:0] k;       // trigger detected at the k-th edge of the period
        logic        ok;      // 1: accepted, output high afterwards
        logic [15:0] follow;  // following high time (ok) or remaining low time
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'd20, 16'd2,  1'b0, 16'd8},
        '{16'd20, 16'd10, 1'b0, 16'd8},
        '{16'd20, 16'd11, 1'b1, 16'd20},
        '{16'd20, 16'd15, 1'b1, 16'd20},
        '{16'd20, 16'd20, 1'b1, 16'd20},
        '{16'd20, 16'd21, 1'b0, 16'd7},
        '{16'd21, 16'd10, 1'b0, 16'd8},
        '{16'd21, 16'd11, 1'b1, 16'd21},
        '{16'd8,  16'd4,  1'b0, 16'd8},
        '{16'd8,  16'd5,  1'b1, 16'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b1;
    logic        disable_i = 1'b0;
    logic [15:0] period_cyc_i = 16'd20;
    logic [15:0] powerup_cyc_i = 16'(PU);
    logic        trig_i = 1'b1;
    logic        wdrst_n_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_top #(.PULSE_CYC(PULSE)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .enable_i      (enable_i),
        .disable_i     (disable_i),
        .period_cyc_i  (period_cyc_i),
        .powerup_cyc_i (powerup_cyc_i),
        .trig_i        (trig_i),
        .wdrst_n_o     (wdrst_n_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        trig_i = 1'b1;
        enable_i = 1'b1;
        disable_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // cycles until the output is first seen low
    task automatic high_len(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            n++;
            if (!wdrst_n_o) break;
        end
    endtask

    // called on a low sample; number of low samples from here on
    task automatic low_len(output int n);
        n = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (wdrst_n_o) break;
            n++;
        end
    endtask

    // falling edge, detected at the next rising edge
    task automatic pulse_trig();
        trig_i = 1'b0;
        @(negedge clk);
        trig_i = 1'b1;
    endtask

    task automatic enter_run();
        do_reset();
        pulse_trig();
    endtask

    initial begin
        int n;
        int m;
        int lows;

        // reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 output high in reset", int'(wdrst_n_o), 1);

        // vector table: windowed trigger placement
        powerup_cyc_i = 16'd50;
        for (int i = 0; i < NVEC; i++) begin
            period_cyc_i = VECS[i].per;
            enter_run();
            repeat (int'(VECS[i].k) - 1) @(negedge clk);
            pulse_trig();
            if (VECS[i].k > VECS[i].per)
                check("R7 expiry before late trigger", int'(wdrst_n_o), 0);
            else if (VECS[i].ok)
                check("R5 trigger in window keeps output high", int'(wdrst_n_o), 1);
            else
                check("R6 early trigger pulls output low", int'(wdrst_n_o), 0);
            if (VECS[i].ok) begin
                high_len(n);
                check("R5 new period after accepted trigger", n, int'(VECS[i].follow));
            end else begin
                low_len(n);
                check("R6 remaining pulse length", n, int'(VECS[i].follow));
            end
        end

        // R3: power-up expiry repeats
        powerup_cyc_i = 16'(PU);
        period_cyc_i = 16'd20;
        do_reset();
        high_len(n);
        check("R3 first power-up expiry", n, PU);
        low_len(n);
        check("R3 pulse length", n, PULSE);
        high_len(n);
        check("R3 power-up phase restarts", n, PU);
        low_len(n);
        check("R3 second pulse length", n, PULSE);

        // R1: trigger held low through reset, then a rising edge only
        rst = 1'b1;
        trig_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 steady low level is no trigger", int'(wdrst_n_o), 1);
        trig_i = 1'b1;
        high_len(n);
        check("R1 rising edge does not restart timing", 5 + n, PU);

        // R2, R4, R7, R8, R9
        enter_run();
        check("R2 power-up trigger accepted without pulse", int'(wdrst_n_o), 1);
        high_len(n);
        check("R4 R7 first period expires after P", n, 20);
        low_len(n);
        check("R7 expiry pulse length", n, PULSE);
        high_len(n);
        check("R8 next period starts at pulse end", n, 20);
        pulse_trig();
        low_len(n);
        check("R9 edge during pulse ignored, pulse length", n, PULSE - 1);
        high_len(n);
        check("R9 period after ignored edge", n, 20);

        // R10: disable
        do_reset();
        disable_i = 1'b1;
        lows = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!wdrst_n_o) lows++;
            if (i == 7) pulse_trig();
        end
        check("R10 output high while disabled", lows, 0);
        disable_i = 1'b0;
        high_len(n);
        check("R10 fresh power-up after disable", n, PU);

        // R11: enable low in the middle of a pulse
        enter_run();
        high_len(n);
        repeat (2) @(negedge clk);
        check("R11 pulse in progress before enable drop", int'(wdrst_n_o), 0);
        enable_i = 1'b0;
        @(negedge clk);
        check("R11 pulse cut off by enable low", int'(wdrst_n_o), 1);
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!wdrst_n_o) lows++;
        end
        check("R11 output held high while not enabled", lows, 0);
        enable_i = 1'b1;
        high_len(m);
        check("R11 re-enable starts power-up phase", m, PU);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule